// File: doc/BRIEF.md
# Serial-Bus Tuning Synthesizer Register Slave

This block is a two-wire serial bus (I2C) slave that holds the programming state of a frequency synthesizer: a 15-bit loop divider, a control word, and four band-select outputs. The bus lines are sampled with the system clock. The slave drives SDA only by pulling it low, so the pad is open-drain. The device address is fixed in its upper five bits. The two lowest address bits come from a hardware selection input, so four synthesizers can share one bus.

After a write address, the slave does not use a register pointer. The most significant bit of each data byte chooses where it goes. A byte that starts with 0 carries the upper seven divider bits, and the byte after it carries the lower eight; both halves take effect together. A byte that starts with 1 is a control word, and the byte after it sets the band outputs. Several such groups can be sent one after another under a single address until STOP.

After a read address, the slave returns a status byte. The byte holds a power-up flag, the loop lock input and a three-bit level code. The slave repeats the status byte for as long as the master acknowledges it.

Top module: `tunectl_i2c_slave`

## Requirements
- R1: The slave acknowledges (SDA low in the ninth clock) an address byte whose upper seven bits equal 1,1,0,0,0 followed by `addr_sel[1]`,`addr_sel[0]`. Bit 0 of the address byte selects read when 1 and write when 0. Any other address gets no acknowledge, and the data bytes that follow are neither acknowledged nor applied.
- R2: A write byte with bit 7 = 0 stores its bits 6..0 as divider bits 14..8. The next byte supplies divider bits 7..0. `divider` changes only when that second byte completes, and it never changes after the first byte alone.
- R3: A write byte with bit 7 = 1 is a control word and takes effect at the end of that byte. Its fields are: bit 6 → `cp_high`, bits 5..3 → `test_mode[2:0]`, bits 2..1 → `ref_div_sel[1:0]`, bit 0 → `amp_off`.
- R4: The byte that follows a control word sets `band_out` from its bits 3..0, and bits 7..4 are ignored. It takes effect at the end of that byte.
- R5: After each completed divider pair or control/band pair, the next byte is classified again by its bit 7, with no new address needed before STOP.
- R6: A divider upper byte followed by STOP or START, instead of its lower byte, is discarded. `divider` keeps its old value, and the next transaction classifies its first byte anew.
- R7: The status byte is sent MSB first as {power-up flag, `pll_locked`, 1, 1, 1, `level_code[2:0]`}. The level code uses 000, 001, 010, 011 and 100 for five ascending input ranges and is passed through unchanged.
- R8: The power-up flag is 1 after reset. It is cleared once a status byte has been fully sent, so later status bytes show 0.
- R9: The slave acknowledges every byte of an addressed write. It releases SDA after the master does not acknowledge a status byte, and it changes its SDA drive only while SCL is low.
- R10: Reset gives `divider`=0, `band_out`=0, `cp_high`=0, `test_mode`=001, `ref_div_sel`=11 and `amp_off`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the pad |
| sda_pull_low | output | 1 | When 1, the open-drain pad pulls SDA low |
| addr_sel | input | 2 | Hardware selection of the two low address bits |
| pll_locked | input | 1 | Loop lock indication reported in status |
| level_code | input | 3 | Five-level input code reported in status |
| divider | output | 15 | Loop divider ratio |
| cp_high | output | 1 | Charge-pump high-current select |
| test_mode | output | 3 | Test mode selection |
| ref_div_sel | output | 2 | Reference divider ratio select |
| amp_off | output | 1 | Tuning amplifier disable |
| band_out | output | 4 | Band-select drive outputs |

## Verification
A table of two-byte write transactions covers every mix of leading bits: divider pairs at the boundary values, and control/band pairs with alternating field patterns. Each row shows whether a byte went to the right target and whether its fields landed in the right positions. One longer stream of three pairs under a single address shows that classification restarts after each pair. A foreign address and an interrupted divider pair show that nothing is applied or left pending. Two back-to-back status reads separate the power-up flag before and after its first delivery, and a read with other lock and level inputs shows those bits passing through.

// File: rtl/tunectl_pkg.sv
package tunectl_pkg;

    localparam logic [4:0] ADDR_FIXED = 5'b11000;

    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_ADDR,
        BUS_WRITE,
        BUS_READ,
        BUS_SKIP
    } bus_st_t;

    typedef enum logic [1:0] {
        RT_ANY,
        RT_DIV_LO,
        RT_BAND
    } route_t;

    typedef struct packed {
        logic       cp_hi;
        logic [2:0] test;
        logic [1:0] ref_sel;
        logic       amp_off;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{cp_hi: 1'b0, test: 3'b001, ref_sel: 2'b11, amp_off: 1'b0};

    function automatic logic addr_hit(input logic [7:0] b, input logic [1:0] sel);
        return b[7:1] == {ADDR_FIXED, sel};
    endfunction

    function automatic ctrl_t decode_ctrl(input logic [7:0] b);
        ctrl_t c;
        c.cp_hi   = b[6];
        c.test    = b[5:3];
        c.ref_sel = b[2:1];
        c.amp_off = b[0];
        return c;
    endfunction

    function automatic logic [7:0] build_status(input logic pwr, input logic lk,
                                                input logic [2:0] lvl);
        return {pwr, lk, 3'b111, lvl};
    endfunction

endpackage

// File: rtl/tunectl_linesync.sv
module tunectl_linesync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_p, sda_p;
    logic              scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_in};
            sda_p <= {sda_p[STAGES-2:0], sda_in};
            scl_d <= scl_p[STAGES-1];
            sda_d <= sda_p[STAGES-1];
        end
    end

    assign scl_q     = scl_p[STAGES-1];
    assign sda_q     = sda_p[STAGES-1];
    assign scl_rise  = scl_q & ~scl_d;
    assign scl_fall  = ~scl_q & scl_d;
    assign start_det = scl_q & scl_d & sda_d & ~sda_q;
    assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/tunectl_serial.sv
module tunectl_serial
    import tunectl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sda_q,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [1:0] sel,
    input  logic [7:0] status_byte,
    output logic       sda_low,
    output logic       wr_stb,
    output logic [7:0] wr_byte,
    output logic       frame_rst,
    output logic       por_clr
);
    bus_st_t    st;
    logic [3:0] cnt;
    logic [7:0] rx, tx;
    logic       hit, go_read, mack;
    logic [2:0] bit_idx;

    always_comb bit_idx = 3'(4'd7 - cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= BUS_IDLE;
            cnt       <= '0;
            rx        <= '0;
            tx        <= '0;
            hit       <= 1'b0;
            go_read   <= 1'b0;
            mack      <= 1'b0;
            sda_low   <= 1'b0;
            wr_stb    <= 1'b0;
            wr_byte   <= '0;
            frame_rst <= 1'b0;
            por_clr   <= 1'b0;
        end else begin
            wr_stb    <= 1'b0;
            frame_rst <= 1'b0;
            por_clr   <= 1'b0;
            if (start_det) begin
                st        <= BUS_ADDR;
                cnt       <= '0;
                sda_low   <= 1'b0;
                frame_rst <= 1'b1;
            end else if (stop_det) begin
                st        <= BUS_IDLE;
                cnt       <= '0;
                sda_low   <= 1'b0;
                frame_rst <= 1'b1;
            end else if (st != BUS_IDLE) begin
                if (scl_rise) begin
                    if (cnt < 4'd8) rx <= {rx[6:0], sda_q};
                    else if (cnt == 4'd8) mack <= ~sda_q;
                    if (cnt < 4'd9) cnt <= cnt + 4'd1;
                end else if (scl_fall) begin
                    if (cnt == 4'd8) begin
                        case (st)
                            BUS_ADDR: begin
                                hit     <= addr_hit(rx, sel);
                                go_read <= rx[0];
                                sda_low <= addr_hit(rx, sel);
                            end
                            BUS_WRITE: begin
                                wr_stb  <= 1'b1;
                                wr_byte <= rx;
                                sda_low <= 1'b1;
                            end
                            BUS_READ: begin
                                por_clr <= 1'b1;
                                sda_low <= 1'b0;
                            end
                            default: sda_low <= 1'b0;
                        endcase
                    end else if (cnt == 4'd9) begin
                        cnt <= '0;
                        case (st)
                            BUS_ADDR: begin
                                if (hit && go_read) begin
                                    st      <= BUS_READ;
                                    tx      <= status_byte;
                                    sda_low <= ~status_byte[7];
                                end else if (hit) begin
                                    st      <= BUS_WRITE;
                                    sda_low <= 1'b0;
                                end else begin
                                    st      <= BUS_SKIP;
                                    sda_low <= 1'b0;
                                end
                            end
                            BUS_READ: begin
                                if (mack) begin
                                    tx      <= status_byte;
                                    sda_low <= ~status_byte[7];
                                end else begin
                                    st      <= BUS_SKIP;
                                    sda_low <= 1'b0;
                                end
                            end
                            default: sda_low <= 1'b0;
                        endcase
                    end else if (st == BUS_READ && cnt != 4'd0) begin
                        sda_low <= ~tx[bit_idx];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/tunectl_regfile.sv
module tunectl_regfile
    import tunectl_pkg::*;
#(
    parameter int DIV_W  = 15,
    parameter int BAND_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [7:0]        wr_byte,
    input  logic              frame_rst,
    input  logic              por_clr,
    output logic [DIV_W-1:0]  divider,
    output ctrl_t             ctrl,
    output logic [BAND_W-1:0] band,
    output logic              por
);
    localparam int HI_W = DIV_W - 8;

    route_t          route;
    logic [HI_W-1:0] hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            route   <= RT_ANY;
            hold    <= '0;
            divider <= '0;
            ctrl    <= CTRL_RST;
            band    <= '0;
            por     <= 1'b1;
        end else begin
            if (por_clr) por <= 1'b0;
            if (frame_rst) begin
                route <= RT_ANY;
            end else if (wr_stb) begin
                case (route)
                    RT_DIV_LO: begin
                        divider <= {hold, wr_byte};
                        route   <= RT_ANY;
                    end
                    RT_BAND: begin
                        band  <= wr_byte[BAND_W-1:0];
                        route <= RT_ANY;
                    end
                    default: begin
                        if (wr_byte[7]) begin
                            ctrl  <= decode_ctrl(wr_byte);
                            route <= RT_BAND;
                        end else begin
                            hold  <= wr_byte[HI_W-1:0];
                            route <= RT_DIV_LO;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/tunectl_i2c_slave.sv
module tunectl_i2c_slave
    import tunectl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 15,
    parameter int BAND_W      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull_low,
    input  logic [1:0]        addr_sel,
    input  logic              pll_locked,
    input  logic [2:0]        level_code,
    output logic [DIV_W-1:0]  divider,
    output logic              cp_high,
    output logic [2:0]        test_mode,
    output logic [1:0]        ref_div_sel,
    output logic              amp_off,
    output logic [BAND_W-1:0] band_out
);
    logic       scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_stb, frame_rst, por_clr, por;
    logic [7:0] wr_byte, status_byte;
    ctrl_t      ctrl;

    tunectl_linesync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign status_byte = build_status(por, pll_locked, level_code);

    tunectl_serial u_ser (
        .clk(clk), .rst(rst), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sel(addr_sel),
        .status_byte(status_byte), .sda_low(sda_pull_low), .wr_stb(wr_stb),
        .wr_byte(wr_byte), .frame_rst(frame_rst), .por_clr(por_clr)
    );

    tunectl_regfile #(.DIV_W(DIV_W), .BAND_W(BAND_W)) u_regs (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_byte(wr_byte),
        .frame_rst(frame_rst), .por_clr(por_clr), .divider(divider),
        .ctrl(ctrl), .band(band_out), .por(por)
    );

    assign cp_high     = ctrl.cp_hi;
    assign test_mode   = ctrl.test;
    assign ref_div_sel = ctrl.ref_sel;
    assign amp_off     = ctrl.amp_off;
endmodule

// File: rtl/tunectl_i2c_chk.sv
module tunectl_i2c_chk #(
    parameter int DIV_W  = 15,
    parameter int BAND_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_q,
    input logic              sda_low,
    input logic              wr_stb,
    input logic              por,
    input logic [DIV_W-1:0]  divider,
    input logic [BAND_W-1:0] band,
    input logic [6:0]        ctrl_bits
);
    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (divider == '0 && band == '0 && ctrl_bits == 7'b0001110 && por));

    // R2
    div_update_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(divider) |-> $past(wr_stb));

    // R3
    ctrl_update_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_bits) |-> $past(wr_stb));

    // R4
    band_update_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(band) |-> $past(wr_stb));

    // R8
    por_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(por));

    // R9
    sda_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_low) |-> !scl_q);
endmodule

bind tunectl_i2c_slave tunectl_i2c_chk #(.DIV_W(DIV_W), .BAND_W(BAND_W)) u_chk (
    .clk(clk), .rst(rst), .scl_q(scl_q), .sda_low(sda_pull_low), .wr_stb(wr_stb),
    .por(por), .divider(divider), .band(band_out),
    .ctrl_bits({cp_high, test_mode, ref_div_sel, amp_off})
);

// File: tb/sim_tunectl_i2c_slave.sv
module sim_tunectl_i2c_slave;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        scl = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_bus;
    logic [1:0]  addr_sel = 2'b01;
    logic        lock = 1'b0;
    logic [2:0]  level = 3'b000;
    logic        sda_pull_low, cp_high, amp_off;
    logic [14:0] divider;
    logic [2:0]  test_mode;
    logic [1:0]  ref_div_sel;
    logic [3:0]  band_out;

    assign sda_bus = ~(m_low | sda_pull_low);

    tunectl_i2c_slave u0 (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus), .sda_pull_low(sda_pull_low),
        .addr_sel(addr_sel), .pll_locked(lock), .level_code(level), .divider(divider),
        .cp_high(cp_high), .test_mode(test_mode), .ref_div_sel(ref_div_sel),
        .amp_off(amp_off), .band_out(band_out)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    localparam int Q = 6;
    localparam logic [7:0] WR_ADDR = 8'hC2;
    localparam logic [7:0] RD_ADDR = 8'hC3;

    // {byte1, byte2, expected divider, expected control bits, expected band}
    localparam logic [41:0] VEC [5] = '{
        {8'h12, 8'h34, 15'h1234, 7'h0E, 4'h0},
        {8'hC1, 8'h05, 15'h1234, 7'h41, 4'h5},
        {8'h7F, 8'hFF, 15'h7FFF, 7'h41, 4'h5},
        {8'h8A, 8'hFA, 15'h7FFF, 7'h0A, 4'hA},
        {8'h00, 8'h01, 15'h0001, 7'h0A, 4'hA}
    };

    task automatic waitq(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        m_low = ~b; waitq(); scl = 1'b1; waitq(2); scl = 1'b0; waitq();
    endtask

    task automatic recv_bit(output logic b);
        m_low = 1'b0; waitq(); scl = 1'b1; waitq(); b = sda_bus; waitq(); scl = 1'b0; waitq();
    endtask

    task automatic start_c();
        m_low = 1'b0; waitq(); scl = 1'b1; waitq(); m_low = 1'b1; waitq(); scl = 1'b0; waitq();
    endtask

    task automatic stop_c();
        m_low = 1'b1; waitq(); scl = 1'b1; waitq(); m_low = 1'b0; waitq(2);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(s);
        acked = ~s;
    endtask

    task automatic read_byte(output logic [7:0] b, input logic mack);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            recv_bit(s);
            b = {b[6:0], s};
        end
        send_bit(~mack);
    endtask

    function automatic logic [6:0] ctrl_now();
        return {cp_high, test_mode, ref_div_sel, amp_off};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic       ack, s;
        logic [7:0] rb;
        logic [41:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R10 reset state
        check("R10 divider", 32'(divider), 32'h0);
        check("R10 control", 32'(ctrl_now()), 32'h0E);
        check("R10 band", 32'(band_out), 32'h0);

        // R7 R8 status reads with POR, then cleared; R9 release after NACK
        lock = 1'b1; level = 3'b011;
        start_c();
        write_byte(RD_ADDR, ack);
        check("R1 read address ack", 32'(ack), 32'h1);
        read_byte(rb, 1'b1);
        check("R7 R8 first status", 32'(rb), 32'hFB);
        read_byte(rb, 1'b0);
        check("R8 status after clear", 32'(rb), 32'h7B);
        recv_bit(s);
        check("R9 released after NACK", 32'(s), 32'h1);
        stop_c();

        // table of two-byte writes
        for (int i = 0; i < 5; i++) begin
            v = VEC[i];
            start_c();
            write_byte(WR_ADDR, ack);
            check("R1 write address ack", 32'(ack), 32'h1);
            write_byte(v[41:34], ack);
            check("R9 first data ack", 32'(ack), 32'h1);
            write_byte(v[33:26], ack);
            check("R9 second data ack", 32'(ack), 32'h1);
            stop_c();
            check("R2 divider", 32'(divider), 32'(v[25:11]));
            check("R3 control", 32'(ctrl_now()), 32'(v[10:4]));
            check("R4 band", 32'(band_out), 32'(v[3:0]));
        end

        // R5 stream of three pairs under one address
        start_c();
        write_byte(WR_ADDR, ack);
        write_byte(8'h01, ack);
        write_byte(8'h02, ack);
        write_byte(8'h03, ack);
        write_byte(8'h04, ack);
        write_byte(8'h84, ack);
        write_byte(8'h09, ack);
        check("R5 last stream ack", 32'(ack), 32'h1);
        stop_c();
        check("R5 stream divider", 32'(divider), 32'h0304);
        check("R5 stream control", 32'(ctrl_now()), 32'h04);
        check("R5 stream band", 32'(band_out), 32'h9);

        // R1 foreign address: no ack, nothing applied
        start_c();
        write_byte(8'hC4, ack);
        check("R1 foreign address nack", 32'(ack), 32'h0);
        write_byte(8'hFF, ack);
        check("R1 foreign data nack", 32'(ack), 32'h0);
        write_byte(8'h0F, ack);
        stop_c();
        check("R1 foreign control kept", 32'(ctrl_now()), 32'h04);
        check("R1 foreign band kept", 32'(band_out), 32'h9);

        // R6 lone upper divider byte discarded at STOP
        start_c();
        write_byte(WR_ADDR, ack);
        write_byte(8'h15, ack);
        stop_c();
        check("R6 divider kept", 32'(divider), 32'h0304);
        start_c();
        write_byte(WR_ADDR, ack);
        write_byte(8'h05, ack);
        write_byte(8'h06, ack);
        stop_c();
        check("R6 fresh classification", 32'(divider), 32'h0506);

        // R2 divider unchanged between the two halves
        start_c();
        write_byte(WR_ADDR, ack);
        write_byte(8'h7A, ack);
        check("R2 mid pair unchanged", 32'(divider), 32'h0506);
        write_byte(8'h11, ack);
        check("R2 pair applied", 32'(divider), 32'h7A11);
        stop_c();

        // R7 other lock and level values
        lock = 1'b0; level = 3'b100;
        start_c();
        write_byte(RD_ADDR, ack);
        read_byte(rb, 1'b0);
        check("R7 status pass-through", 32'(rb), 32'h3C);
        stop_c();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule